// File: doc/BRIEF.md
# Ternary-Weight Dot-Product Accumulator

This block computes the dot product of a vector of signed 8-bit integer activations and a vector of ternary weights without a single multiplier. Every weight is -1, 0 or +1, carried on two bits. Each lane therefore adds its activation, subtracts it, or contributes nothing. The lane terms of one beat are summed by a small reduction and added into a wide signed accumulator.

A vector arrives as a stream of beats, each carrying `LANES` activation/weight pairs. One beat is accepted per clock while `in_valid` is high. The first beat of a vector is flagged with `in_first`, which restarts the accumulation. The last beat is flagged with `in_last`. One clock after that last beat, `out_valid` pulses for a single cycle and `out_sum` holds the completed dot product. `out_sum` keeps that value until the next accepted beat.

Top module: `tern_dot_acc`

## Requirements
- R1: A weight code 2'b01 contributes the activation unchanged, 2'b11 contributes its negation, and 2'b00 contributes zero; lane `i` uses bits `[8*i+7:8*i]` of `in_act` and bits `[2*i+1:2*i]` of `in_wgt`.
- R2: The unused weight code 2'b10 contributes zero, exactly like 2'b00.
- R3: Negating an activation of -128 yields +128; it never wraps back to -128.
- R4: A beat accepted with `in_first` high discards the previous total, so the vector's sum starts from that beat's own terms.
- R5: After reset `out_valid` is low and `out_sum` reads zero; `out_valid` is high in exactly the cycle after a beat accepted with `in_last` high, and low otherwise.
- R6: While `in_valid` is low, the data, weights, `in_first` and `in_last` are ignored: the running total does not change and `out_valid` stays low.
- R7: For a vector spanning several beats, `out_sum` equals the signed sum over all beats and lanes of activation times weight value.
- R8: `out_sum` is a 24-bit two's-complement value and gives the exact total for vectors of up to 65535 elements, including all-extreme inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Beat on the inputs is accepted this cycle |
| in_first | input | 1 | Accepted beat opens a new vector |
| in_last | input | 1 | Accepted beat closes the vector |
| in_act | input | 32 | Four signed 8-bit activations, lane 0 in the low byte |
| in_wgt | input | 8 | Four 2-bit ternary weight codes, lane 0 in the low bits |
| out_valid | output | 1 | One-cycle pulse marking a completed dot product |
| out_sum | output | 24 | Signed dot-product total |

## Verification
The assertions assume that every vector starts with an accepted `in_first` beat and stays within the R8 length limit. Under those conditions, the running total and the per-lane terms remain within the bounds the checks rely on.

The stimulus always flags beat zero of each vector as first and keeps the longest vector at 65532 elements. Idle cycles between beats deliberately carry random data and set both markers. This shows that nothing is taken from an idle cycle.

// File: rtl/tdp_pkg.sv
// Shared definitions for the ternary dot-product accumulator.
// Assumes weights arrive as 2-bit codes; the unused code decodes to zero.
package tdp_pkg;

    localparam int WCODE_W = 2;

    typedef enum logic [WCODE_W-1:0] {
        WC_NULL = 2'b00,
        WC_PLUS = 2'b01,
        WC_RSVD = 2'b10,
        WC_MINUS = 2'b11
    } wcode_t;

endpackage

// File: rtl/tern_lane.sv
// One multiplier-free lane: turns an activation and a ternary weight code
// into a signed term one bit wider than the activation (so -(-128) = +128).
// Assumes a two's-complement activation; purely combinational.
module tern_lane
    import tdp_pkg::*;
#(
    parameter int ACT_W = 8,
    localparam int TERM_W = ACT_W + 1
) (
    input  logic [ACT_W-1:0]   act,
    input  logic [WCODE_W-1:0] wgt,
    output logic [TERM_W-1:0]  term
);

    logic signed [TERM_W-1:0] act_ext;
    logic signed [TERM_W-1:0] term_s;

    // Widen the activation before any negation so the extreme value survives.
    always_comb act_ext = TERM_W'($signed(act));

    // Select add, subtract or skip according to the weight code.
    always_comb begin
        unique case (wcode_t'(wgt))
            WC_PLUS:  term_s = act_ext;
            WC_MINUS: term_s = -act_ext;
            default:  term_s = '0;
        endcase
    end

    assign term = term_s;

    // Lane output checks (immediate assertions).
    always_comb begin
        a_r3_term_range: assert (term_s >= -(TERM_W'(1) <<< (ACT_W-1)) &&
                                 term_s <= (TERM_W'(1) <<< (ACT_W-1)))
            else $error("lane term outside activation magnitude");
        if (wgt == 2'b10)
            a_r2_reserved_null: assert (term_s == '0)
                else $error("reserved weight code contributed");
        if (wgt == 2'b00)
            a_r1_zero_null: assert (term_s == '0)
                else $error("zero weight contributed");
    end

endmodule

// File: rtl/tern_sum_tree.sv
// Sums the lane terms of one beat into a single signed value, widened by
// clog2(LANES) bits so the reduction itself cannot overflow.
// Assumes each term is a signed TERM_W-bit value packed lane 0 lowest.
module tern_sum_tree #(
    parameter int LANES  = 4,
    parameter int TERM_W = 9,
    localparam int SUM_W = TERM_W + $clog2(LANES)
) (
    input  logic [LANES*TERM_W-1:0] terms,
    output logic [SUM_W-1:0]        sum
);

    logic signed [SUM_W-1:0] sum_s;

    // Sign-extend each term and add them together.
    always_comb begin
        sum_s = '0;
        for (int i = 0; i < LANES; i++) begin
            sum_s = sum_s + SUM_W'($signed(terms[i*TERM_W +: TERM_W]));
        end
    end

    assign sum = sum_s;

    // Beat-sum bound: no more than LANES times the largest term magnitude.
    always_comb begin
        a_r7_tree_bound: assert (sum_s >= -(SUM_W'(LANES) <<< (TERM_W-2)) &&
                                 sum_s <= (SUM_W'(LANES) <<< (TERM_W-2)))
            else $error("beat sum out of range");
    end

endmodule

// File: rtl/tern_dot_acc.sv
// Ternary-weight dot-product accumulator top. Takes LANES activation/weight
// pairs per accepted beat, reduces them, and accumulates into ACC_W bits.
// Assumes every vector opens with a first-flagged beat and stays within the
// element count that ACC_W can hold.
module tern_dot_acc
    import tdp_pkg::*;
#(
    parameter int LANES = 4,
    parameter int ACT_W = 8,
    parameter int ACC_W = 24,
    localparam int TERM_W = ACT_W + 1,
    localparam int SUM_W  = TERM_W + $clog2(LANES)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic                     in_first,
    input  logic                     in_last,
    input  logic [LANES*ACT_W-1:0]   in_act,
    input  logic [LANES*WCODE_W-1:0] in_wgt,
    output logic                     out_valid,
    output logic [ACC_W-1:0]         out_sum
);

    logic [LANES*TERM_W-1:0] lane_terms;
    logic [SUM_W-1:0]        beat_sum;
    logic signed [ACC_W-1:0] acc;
    logic signed [ACC_W-1:0] acc_base;
    logic                    done_q;

    // One decode lane per element of the beat.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        tern_lane #(.ACT_W(ACT_W)) u_lane (
            .act  (in_act[g*ACT_W +: ACT_W]),
            .wgt  (in_wgt[g*WCODE_W +: WCODE_W]),
            .term (lane_terms[g*TERM_W +: TERM_W])
        );
    end

    tern_sum_tree #(.LANES(LANES), .TERM_W(TERM_W)) u_tree (
        .terms (lane_terms),
        .sum   (beat_sum)
    );

    // Start from zero on a first beat, otherwise from the running total.
    always_comb acc_base = in_first ? '0 : acc;

    // Running total: updated only on accepted beats.
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc <= '0;
        else if (in_valid)
            acc <= acc_base + ACC_W'($signed(beat_sum));
    end

    // Result strobe: one cycle after the closing beat.
    always_ff @(posedge clk) begin
        if (!rst_n)
            done_q <= 1'b0;
        else
            done_q <= in_valid & in_last;
    end

    assign out_valid = done_q;
    assign out_sum   = acc;

    // Result strobe follows the closing beat by exactly one cycle.
    a_r5_result_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_last) |=> out_valid)
        else $error("missing result strobe");

    a_r5_result_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_last) |=> !out_valid)
        else $error("spurious result strobe");

    // Idle cycles leave the total untouched.
    a_r6_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_sum))
        else $error("total changed without a valid beat");

endmodule

// File: tb/sim_tern_dot_acc.sv
// Self-checking bench: exhaustive lane sweep, weight patterns, random
// multi-beat vectors with idle gaps, and a maximum-length vector.
module sim_tern_dot_acc;

    localparam int LANES = 4;
    localparam int ACT_W = 8;
    localparam int ACC_W = 24;

    logic                   clk = 1'b0;
    logic                   rst_n;
    logic                   in_valid;
    logic                   in_first;
    logic                   in_last;
    logic [LANES*ACT_W-1:0] in_act;
    logic [LANES*2-1:0]     in_wgt;
    logic                   out_valid;
    logic [ACC_W-1:0]       out_sum;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    tern_dot_acc #(.LANES(LANES), .ACT_W(ACT_W), .ACC_W(ACC_W)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
        .in_last(in_last), .in_act(in_act), .in_wgt(in_wgt),
        .out_valid(out_valid), .out_sum(out_sum)
    );

    function automatic int wval(input logic [1:0] c);
        if (c == 2'b01) return 1;
        if (c == 2'b11) return -1;
        return 0;
    endfunction

    function automatic int res();
        return int'($signed(out_sum));
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Expected contribution of the beat currently on the inputs.
    function automatic int beat_val();
        int s = 0;
        for (int l = 0; l < LANES; l++)
            s += int'($signed(in_act[l*ACT_W +: ACT_W])) * wval(in_wgt[l*2 +: 2]);
        return s;
    endfunction

    // mode: 0 random codes, 1 all zero, 2 all +1, 3 all -1, 4 extreme (-128 by -1)
    task automatic set_beat(input int mode);
        for (int l = 0; l < LANES; l++) begin
            in_act[l*ACT_W +: ACT_W] = (mode == 4) ? 8'h80 : ACT_W'($urandom);
            case (mode)
                1: in_wgt[l*2 +: 2] = 2'b00;
                2: in_wgt[l*2 +: 2] = 2'b01;
                3, 4: in_wgt[l*2 +: 2] = 2'b11;
                default: in_wgt[l*2 +: 2] = 2'($urandom);
            endcase
        end
    endtask

    task automatic run_vec(input int n, input int mode, input bit gaps, input string tag);
        int exp = 0;
        for (int b = 0; b < n; b++) begin
            if (gaps && b > 0 && $urandom_range(0, 2) == 0) begin
                in_valid = 1'b0; in_first = 1'b1; in_last = 1'b1;
                in_act = $urandom; in_wgt = 8'($urandom);
                @(negedge clk);
                chk(out_valid == 1'b0, "R6 idle strobe", int'(out_valid), 0);
            end
            in_valid = 1'b1; in_first = (b == 0); in_last = (b == n - 1);
            set_beat(mode);
            exp += beat_val();
            @(negedge clk);
        end
        in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
        chk(out_valid == 1'b1, "R5 strobe after last", int'(out_valid), 1);
        chk(res() == exp, tag, res(), exp);
        @(negedge clk);
        chk(out_valid == 1'b0, "R5 strobe single cycle", int'(out_valid), 0);
        chk(res() == exp, "R6 total held", res(), exp);
    endtask

    // Single-beat vector with one active lane; others carry weight 00.
    task automatic run_single(input int lane, input int a, input logic [1:0] c);
        int exp;
        in_valid = 1'b1; in_first = 1'b1; in_last = 1'b1;
        in_act = $urandom; in_wgt = '0;
        in_act[lane*ACT_W +: ACT_W] = ACT_W'(a);
        in_wgt[lane*2 +: 2] = c;
        exp = a * wval(c);
        @(negedge clk);
        in_valid = 1'b0;
        if (c == 2'b10)
            chk(res() == exp, "R2 reserved code", res(), exp);
        else if (c == 2'b11 && a == -128)
            chk(res() == exp, "R3 negate -128", res(), exp);
        else
            chk(res() == exp, "R1 lane term", res(), exp);
    endtask

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
        in_act = '0; in_wgt = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R5 reset strobe", int'(out_valid), 0);
        chk(res() == 0, "R5 reset total", res(), 0);

        // R1 R2 R3: every lane, every activation, every code.
        for (int l = 0; l < LANES; l++)
            for (int a = -128; a < 128; a++)
                for (int c = 0; c < 4; c++)
                    run_single(l, a, 2'(c));

        // R7 weight patterns over multi-beat vectors.
        run_vec(17, 1, 1'b0, "R7 all-zero weights");
        run_vec(17, 2, 1'b0, "R7 all-plus weights");
        run_vec(17, 3, 1'b0, "R7 all-minus weights");

        // R4 back-to-back vectors restart from the first beat; R6 gaps.
        for (int v = 0; v < 60; v++)
            run_vec($urandom_range(1, 40), 0, v[0], "R4 R7 random vector");

        // R8 longest vector: 16383 beats of -128 by -1.
        run_vec(16383, 4, 1'b0, "R8 extreme length total");

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule